// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between an on-chip valid/ready request bus and an external asynchronous static RAM organised as one million 4-bit words. It takes one read or write command at a time and plays it out as a fixed sequence of active-low chip select, write enable and output enable levels. The 20-bit address is held steady on the pins for as long as chip select is low. The 4-bit data bus is split into a driven value, a sampled value and a driver enable, so the pad tri-state cell can live outside this block.

Every phase length is a whole number of clock cycles, derived at elaboration from the clock period and the memory's minimum timings. The write pulse length comes from the minimum write pulse width. The read wait comes from the worst-case access time, plus a synchroniser stage. The turnaround after a read comes from the memory's output release time. The order of the strobes means the controller never drives the data bus while the memory might still be driving it.

A read result comes back as a one-cycle `rsp_valid` pulse carrying the captured word. Writes produce no response. `req_ready` goes high again when the memory can take the next command.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and at once while reset is held low (asynchronous), `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A command is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the sequence ends. With `req_ready` high, all strobes are inactive and the data driver is off.
- R3: On a write (`req_write`=1), the edge that accepts it pulls `mem_cs_n` and `mem_we_n` low together. The same edge presents the address, presents the data and turns on the driver, while `mem_oe_n` stays 1. `mem_we_n` stays low for exactly WP = ceil(T_WE_PULSE_PS / CLK_PERIOD_PS) cycles, which is 3 with the default parameters.
- R4: When `mem_we_n` and `mem_cs_n` rise, `mem_dq_oe` is still 1 and `mem_dq_out` is unchanged. The driver turns off one cycle later, and `req_ready` returns in that same cycle.
- R5: `mem_addr` does not change while `mem_cs_n` stays low.
- R6: On a read (`req_write`=0), `mem_cs_n` and `mem_oe_n` are low, with `mem_we_n` high and the driver off, for exactly ACC = ceil(T_ACCESS_PS / CLK_PERIOD_PS) cycles. With the defaults this is 3.
- R7: `rsp_valid` pulses for a single cycle, ACC + SYNC_STAGES cycles after the accepting edge. `rsp_rdata` then equals the word the memory drove for that address. `rsp_valid` is 0 at all other times.
- R8: After a read, `req_ready` returns ACC + SYNC_STAGES + TA cycles after the accepting edge, where TA = ceil(T_RELEASE_PS / CLK_PERIOD_PS). The driver is not enabled until `mem_oe_n` has been high for at least TA cycles.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle and able to take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 4 | Read result |
| mem_addr | output | 20 | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Value for the data pad driver |
| mem_dq_in | input | 4 | Value sampled from the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable, active high |

## Verification
All strobes are registered, so each command's first pin change shows up in the cycle that starts at its accepting edge. The bench counts sample points from that edge, taking each sample on the falling clock edge. For a write it expects the write strobe low at samples 0..WP-1, the strobe high with the data still driven at sample WP, and the driver off with ready back at sample WP+1. For a read it expects the strobes low at samples 0..ACC-1, the result pulse only at sample ACC+SYNC_STAGES, and ready only at sample ACC+SYNC_STAGES+TA. The next command is issued at the first sample where ready is seen, so the read-to-write turnaround is exercised at its shortest legal spacing.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WR_STB  = 3'd1,
      ST_WR_HOLD = 3'd2,
      ST_RD_STB  = 3'd3,
      ST_RD_SYNC = 3'd4,
      ST_TURN    = 3'd5
   } ctl_state_e;

   // whole cycles covering a time budget, never less than one
   function automatic int phase_cycles(input int t_ps, input int clk_ps);
      int n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_din_sync.sv
module sram_din_sync #(
   parameter int DATA_W = 4,
   parameter int STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [DATA_W-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [DATA_W-1:0] s_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q[0] <= '0;
            else        s_q[0] <= d;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) s_q[i] <= '0;
               else        s_q[i] <= s_q[i-1];
            end
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 4,
   parameter int CLK_PERIOD_PS = 4000,
   parameter int T_WE_PULSE_PS = 10000,
   parameter int T_ACCESS_PS   = 12000,
   parameter int T_RELEASE_PS  = 6000,
   parameter int SYNC_STAGES   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   localparam int WP_CYC  = phase_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS);
   localparam int ACC_CYC = phase_cycles(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int TA_CYC  = phase_cycles(T_RELEASE_PS, CLK_PERIOD_PS);
   localparam int MAX_PH  = max4(WP_CYC, ACC_CYC, TA_CYC, SYNC_STAGES);
   localparam int CNT_W   = $clog2(MAX_PH + 1);

   // elaboration-time parameter checks
   generate
      if (CLK_PERIOD_PS <= 0) begin : g_bad_clk
         $error("sram_strobe_ctrl: CLK_PERIOD_PS must be positive");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sram_strobe_ctrl: SYNC_STAGES must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_strobe_ctrl: widths must be at least 1");
      end
   endgenerate

   ctl_state_e        state_q;
   logic              accept;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_done;
   logic [DATA_W-1:0] sync_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_din_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mem_dq_in),
      .q     (sync_q)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               tmr_val  = req_write ? CNT_W'(WP_CYC - 1) : CNT_W'(ACC_CYC - 1);
            end
         end
         ST_RD_STB: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SYNC_STAGES - 1);
            end
         end
         ST_RD_SYNC: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(TA_CYC - 1);
            end
         end
         default: begin
            tmr_load = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mem_addr   <= '0;
         mem_cs_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  mem_addr <= req_addr;
                  mem_cs_n <= 1'b0;
                  if (req_write) begin
                     mem_we_n   <= 1'b0;
                     mem_dq_out <= req_wdata;
                     mem_dq_oe  <= 1'b1;
                     state_q    <= ST_WR_STB;
                  end else begin
                     mem_oe_n <= 1'b0;
                     state_q  <= ST_RD_STB;
                  end
               end
            end
            ST_WR_STB: begin
               if (tmr_done) begin
                  mem_we_n <= 1'b1;
                  mem_cs_n <= 1'b1;
                  state_q  <= ST_WR_HOLD;
               end
            end
            ST_WR_HOLD: begin
               mem_dq_oe <= 1'b0;
               state_q   <= ST_IDLE;
            end
            ST_RD_STB: begin
               if (tmr_done) begin
                  mem_cs_n <= 1'b1;
                  mem_oe_n <= 1'b1;
                  state_q  <= ST_RD_SYNC;
               end
            end
            ST_RD_SYNC: begin
               if (tmr_done) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= sync_q;
                  state_q   <= ST_TURN;
               end
            end
            ST_TURN: begin
               if (tmr_done) state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int CLK_PERIOD_PS = 4000,
   parameter int T_WE_PULSE_PS = 10000,
   parameter int T_RELEASE_PS  = 6000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);

   localparam int WP_CYC = phase_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS);
   localparam int TA_CYC = phase_cycles(T_RELEASE_PS, CLK_PERIOD_PS);

   logic [7:0] we_low_cnt;
   logic [7:0] oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt <= '0;
         oe_hi_cnt  <= 8'hFF;
      end else begin
         if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
         else           we_low_cnt <= '0;
         if (mem_oe_n)  oe_hi_cnt  <= (oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1;
         else           oe_hi_cnt  <= '0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)) else $error("AST_IDLE_QUIET"); // R2
   AST_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe)) else $error("AST_WE_OVERLAP"); // R3
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_low_cnt == 8'(WP_CYC))) else $error("AST_WE_WIDTH"); // R3
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe) else $error("AST_DATA_HOLD"); // R4
   AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && mem_we_n) |=> !mem_dq_oe) else $error("AST_DRV_RELEASE"); // R4
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)) else $error("AST_ADDR_STABLE"); // R5
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid) else $error("AST_RSP_PULSE"); // R7
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TA_CYC))) else $error("AST_TURNAROUND"); // R8
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n) else $error("AST_NO_CONTENTION"); // R9

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
   .ADDR_W        (ADDR_W),
   .CLK_PERIOD_PS (CLK_PERIOD_PS),
   .T_WE_PULSE_PS (T_WE_PULSE_PS),
   .T_RELEASE_PS  (T_RELEASE_PS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;

   localparam int CLK_PS = 4000;
   localparam int WP  = (10000 + CLK_PS - 1) / CLK_PS;
   localparam int ACC = (12000 + CLK_PS - 1) / CLK_PS;
   localparam int TA  = (6000 + CLK_PS - 1) / CLK_PS;
   localparam int SY  = 1;
   localparam int NV  = 11;
   // entry = {write, addr[19:0], data[3:0]}; data is the expected word on reads
   localparam logic [24:0] VECS [NV] = '{
      25'h1000005, 25'h1FFFFFA, 25'h0000005, 25'h1123433, 25'h0FFFFFA,
      25'h15A5A6C, 25'h0123433, 25'h05A5A6C, 25'h1000009, 25'h0000009,
      25'h0FFFFFA };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_rdata;
   logic [19:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [3:0]  mem_dq_out;
   logic [3:0]  mem_dq_in;

   int n_chk = 0;
   int n_fail = 0;
   int n_clash = 0;
   bit ended = 1'b0;
   logic [3:0] model_mem [16];

   always #2ns clk = ~clk;

   sram_strobe_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

   // behavioural memory: drives only in read mode, stores during write overlap
   assign mem_dq_in = (!mem_cs_n && mem_we_n && !mem_oe_n) ? model_mem[mem_addr[3:0]] : 4'h0;

   always @(negedge clk) begin
      if (rst_n && !mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr[3:0]] = mem_dq_out;
      if (rst_n && mem_dq_oe && !mem_cs_n && mem_we_n && !mem_oe_n) n_clash++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic check_idle(input string tag);
      chk(mem_cs_n && mem_we_n && mem_oe_n, {tag, " strobes high"},
          {29'd0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h7);
      chk(!mem_dq_oe, {tag, " driver off"}, {31'd0, mem_dq_oe}, 32'd0);
      chk(!rsp_valid, {tag, " rsp_valid low"}, {31'd0, rsp_valid}, 32'd0);
      chk(req_ready, {tag, " ready high"}, {31'd0, req_ready}, 32'd1);
   endtask

   // called at a falling edge; issues one command and checks it sample by sample
   task automatic run_op(input logic wr, input logic [19:0] a, input logic [3:0] d);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      if (wr) begin
         for (int m = 0; m <= WP + 1; m++) begin
            if (m > 0) @(negedge clk);
            if (m < WP) begin
               chk(!mem_cs_n && !mem_we_n && mem_oe_n, "R3 write strobes",
                   {29'd0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h1);
               chk(mem_addr == a, "R5 write address", mem_addr, a);
               chk(mem_dq_oe && mem_dq_out == d, "R3 write data driven", {27'd0, mem_dq_oe, mem_dq_out}, {27'd1, d});
               chk(!req_ready, "R2 busy during write", req_ready, 0);
            end else if (m == WP) begin
               chk(mem_we_n && mem_cs_n, "R3 write pulse ends", {30'd0, mem_cs_n, mem_we_n}, 32'h3);
               chk(mem_dq_oe && mem_dq_out == d, "R4 data held at strobe rise", {27'd0, mem_dq_oe, mem_dq_out}, {27'd1, d});
               chk(!req_ready, "R2 busy in hold", req_ready, 0);
            end else begin
               chk(!mem_dq_oe, "R4 driver released", mem_dq_oe, 0);
               chk(req_ready, "R2 ready after write", req_ready, 1);
            end
         end
      end else begin
         for (int m = 0; m <= ACC + SY + TA; m++) begin
            if (m > 0) @(negedge clk);
            if (m < ACC) begin
               chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R6 read strobes",
                   {28'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h4);
               chk(mem_addr == a, "R5 read address", mem_addr, a);
            end else if (m == ACC) begin
               chk(mem_cs_n && mem_oe_n, "R6 read strobes end", {30'd0, mem_cs_n, mem_oe_n}, 32'h3);
            end
            if (m == ACC + SY) begin
               chk(rsp_valid, "R7 response pulse", rsp_valid, 1);
               chk(rsp_rdata == d, "R7 read data", rsp_rdata, d);
            end else begin
               chk(!rsp_valid, "R7 no stray response", rsp_valid, 0);
            end
            if (m < ACC + SY + TA) chk(!req_ready, "R8 busy through turnaround", req_ready, 0);
            else                   chk(req_ready, "R8 ready after turnaround", req_ready, 1);
         end
      end
   endtask

   initial begin
      #(200000 * 4ns);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) model_mem[i] = 4'h0;
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // vector table, commands issued at the first legal cycle
      for (int v = 0; v < NV; v++) begin
         run_op(VECS[v][24], VECS[v][23:4], VECS[v][3:0]);
      end

      // reset in the middle of a read strobe returns every pin to idle at once
      req_valid = 1'b1; req_write = 1'b0; req_addr = 20'hFFFFF;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(!mem_oe_n, "R6 read under way before reset", mem_oe_n, 0);
      rst_n = 1'b0;
      #1ns;
      check_idle("R1 mid-sequence reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after second reset");

      // memory contents survive the controller reset; write right after a read
      run_op(1'b0, 20'h12343, 4'h3);
      run_op(1'b1, 20'hABCDF, 4'h6);
      run_op(1'b0, 20'h0000F, 4'h6);

      chk(n_clash == 0, "R9 no bus contention", n_clash, 0);
      finish_run();
   end

endmodule